// File: doc/BRIEF.md
# Daisy-Chained Priority Interrupt Unit

This block joins a parameterised row of device interrupt cells to a small processor-side acceptance unit. No device has its own line into the controller. Every cell drives one shared request line, modelled as an active-low wired-AND, so the line is low while any cell holds a pending request. A cell latches the rising edge of its local request into a pending flag. The flag stays set until that cell is acknowledged, so a request that comes in while interrupts are masked is kept.

When the line is low and the global enable flag is set, the acceptance unit issues a one-cycle acknowledge. That pulse enters the head of a serial chain. A cell with nothing pending forwards it to its neighbour in the same cycle. The first pending cell it reaches stops it, puts its vector on the shared vector bus and clears its pending flag. Priority therefore comes only from a cell's place in the chain. Taking an interrupt clears the enable flag. Software can set the flag again during the service routine to allow nesting, or restore it with a return-from-interrupt, after which the next pending device in chain order is taken.

Top module: `daisy_irq_top`

## Requirements
- R1: `irq_line_n_o` is low exactly when at least one bit of `pend_o` is set.
- R2: A cell sets its pending flag on a rising edge of its bit of `dev_req_i`. The flag stays set until that cell is acknowledged. A request held high after its acknowledge does not set the flag again.
- R3: `ack_o` is high in a cycle exactly when the line is low and `int_en_o` is set. It lasts one cycle.
- R4: Index 0 is the head of the chain and has the highest priority. One acknowledge grants only the lowest-indexed pending cell, and every other cell keeps its pending flag.
- R5: At the clock edge that ends an acknowledge cycle, `vec_o` loads the granted cell's vector, taken from bits `[i*VEC_W +: VEC_W]` of `dev_vec_i`. At all other times it holds its value.
- R6: Accepting an interrupt clears `int_en_o` at the same edge. While the flag is clear, no acknowledge is issued and pending flags are kept.
- R7: A pulse on `set_en_i` (re-enable, also usable during service for nesting) or on `rti_i` sets `int_en_o` at the next edge. After that, the highest-priority pending cell is acknowledged.
- R8: A request whose rising edge falls in an acknowledge cycle is not granted in that cycle. It stays pending and is granted at a later pulse.
- R9: After reset, `int_en_o` is 0, `pend_o` is 0, `vec_o` is 0, `ack_o` is 0 and the line is high.
- R10: A cell with no pending request forwards the acknowledge in the same cycle, so a lone request at the tail is acknowledged in the first cycle in which the line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dev_req_i | input | N_DEV | Local request of each device; rising edge counts |
| dev_vec_i | input | N_DEV*VEC_W | Vector identifier of each device, device i in slice i |
| set_en_i | input | 1 | Sets the global enable flag |
| rti_i | input | 1 | Return from interrupt; restores the enable flag |
| irq_line_n_o | output | 1 | Shared active-low request line |
| ack_o | output | 1 | Acknowledge strobe into the head of the chain |
| vec_o | output | VEC_W | Vector captured at the last acknowledge |
| int_en_o | output | 1 | Global interrupt enable flag |
| pend_o | output | N_DEV | Pending flag of each cell |

## Verification
The hardest case to reach from the ports is a new request whose rising edge falls exactly in the cycle when the acknowledge is already moving along the chain toward another cell. The stimulus gets there by first leaving a low-priority device pending while interrupts are masked. It then pulses the enable and raises the head device's request on the first cycle that the acknowledge is visible. The expected result is that the lower device is granted first and the head device waits for the return-from-interrupt. Nesting is reached the same way: a new request is raised during service and the enable is set again before any return.

// File: rtl/daisy_irq_pkg.sv
package daisy_irq_pkg;
  localparam int unsigned DEF_DEVS  = 4;
  localparam int unsigned DEF_VEC_W = 8;
  localparam int unsigned SYNC_LEN  = 2;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = daisy_irq_pkg::SYNC_LEN
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/irq_cell.sv
module irq_cell #(
  parameter int unsigned VEC_W = daisy_irq_pkg::DEF_VEC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             ack_in,
  output logic             ack_out,
  output logic             pull_o,
  output logic             grant_o,
  output logic [VEC_W-1:0] vec_drv_o
);
  logic req_q, req_d;
  logic pend_q, pend_d;
  logic rise;
  logic grant;

  always_comb begin
    rise    = req_i & ~req_q;
    grant   = pend_q & ack_in;
    ack_out = ack_in & ~pend_q;
    req_d   = req_i;
    pend_d  = rise | (pend_q & ~grant);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      pend_q <= pend_d;
    end
  end

  assign pull_o    = pend_q;
  assign grant_o   = grant;
  assign vec_drv_o = grant ? vec_i : '0;

  // R2
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack_in) |=> pend_q);
  // R4
  block_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && ack_in) |-> !ack_out);
  // R10
  pass_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |-> (ack_out == ack_in));
endmodule

// File: rtl/irq_bus_merge.sv
module irq_bus_merge #(
  parameter int unsigned N_DEV = daisy_irq_pkg::DEF_DEVS,
  parameter int unsigned VEC_W = daisy_irq_pkg::DEF_VEC_W
) (
  input  logic [N_DEV-1:0]       pull_i,
  input  logic [N_DEV*VEC_W-1:0] drv_i,
  output logic                   line_n_o,
  output logic [VEC_W-1:0]       vec_bus_o
);
  logic [N_DEV:0]       line_acc;
  logic [VEC_W-1:0]     vec_acc [N_DEV+1];

  assign line_acc[0] = 1'b1;
  assign vec_acc[0]  = '0;

  for (genvar g = 0; g < N_DEV; g++) begin : g_merge
    assign line_acc[g+1] = line_acc[g] & ~pull_i[g];
    assign vec_acc[g+1]  = vec_acc[g] | drv_i[g*VEC_W +: VEC_W];
  end

  assign line_n_o  = line_acc[N_DEV];
  assign vec_bus_o = vec_acc[N_DEV];
endmodule

// File: rtl/irq_accept.sv
module irq_accept #(
  parameter int unsigned VEC_W = daisy_irq_pkg::DEF_VEC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_n_i,
  input  logic             set_en_i,
  input  logic             rti_i,
  input  logic [VEC_W-1:0] vec_bus_i,
  output logic             ack_o,
  output logic             en_o,
  output logic [VEC_W-1:0] vec_o
);
  logic             en_q, en_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             vec_ld;
  logic             ack;

  always_comb begin
    ack    = ~line_n_i & en_q;
    vec_ld = ack;
    vec_d  = vec_ld ? vec_bus_i : vec_q;
    if (ack)                   en_d = 1'b0;
    else if (set_en_i | rti_i) en_d = 1'b1;
    else                       en_d = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      vec_q <= '0;
    end else begin
      en_q  <= en_d;
      vec_q <= vec_d;
    end
  end

  assign ack_o = ack;
  assign en_o  = en_q;
  assign vec_o = vec_q;

  // R3
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  // R6
  mask_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !en_q);
  // R5
  vec_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (vec_q == $past(vec_bus_i)));
  // R5
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> $stable(vec_q));
  // R7
  reenable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && (set_en_i || rti_i)) |=> en_q);
endmodule

// File: rtl/daisy_irq_top.sv
module daisy_irq_top #(
  parameter int unsigned N_DEV = daisy_irq_pkg::DEF_DEVS,
  parameter int unsigned VEC_W = daisy_irq_pkg::DEF_VEC_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_DEV-1:0]       dev_req_i,
  input  logic [N_DEV*VEC_W-1:0] dev_vec_i,
  input  logic                   set_en_i,
  input  logic                   rti_i,
  output logic                   irq_line_n_o,
  output logic                   ack_o,
  output logic [VEC_W-1:0]       vec_o,
  output logic                   int_en_o,
  output logic [N_DEV-1:0]       pend_o
);
  logic                   rst_sync_n;
  logic [N_DEV:0]         ack_chain;
  logic [N_DEV-1:0]       pull;
  logic [N_DEV-1:0]       grant;
  logic [N_DEV*VEC_W-1:0] drv;
  logic                   line_n;
  logic [VEC_W-1:0]       vec_bus;
  logic                   ack;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign ack_chain[0] = ack;

  for (genvar g = 0; g < N_DEV; g++) begin : g_cell
    irq_cell #(.VEC_W(VEC_W)) u_cell (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .req_i     (dev_req_i[g]),
      .vec_i     (dev_vec_i[g*VEC_W +: VEC_W]),
      .ack_in    (ack_chain[g]),
      .ack_out   (ack_chain[g+1]),
      .pull_o    (pull[g]),
      .grant_o   (grant[g]),
      .vec_drv_o (drv[g*VEC_W +: VEC_W])
    );
  end

  irq_bus_merge #(.N_DEV(N_DEV), .VEC_W(VEC_W)) u_merge (
    .pull_i    (pull),
    .drv_i     (drv),
    .line_n_o  (line_n),
    .vec_bus_o (vec_bus)
  );

  irq_accept #(.VEC_W(VEC_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .line_n_i  (line_n),
    .set_en_i  (set_en_i),
    .rti_i     (rti_i),
    .vec_bus_i (vec_bus),
    .ack_o     (ack),
    .en_o      (int_en_o),
    .vec_o     (vec_o)
  );

  assign irq_line_n_o = line_n;
  assign ack_o        = ack;
  assign pend_o       = pull;

  // R4
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(grant));
  // R4
  grant_when_ack_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ack && !line_n) |-> ($countones(grant) == 1));
  // R1
  line_pend_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (line_n == (pull == '0)));
  // R6
  no_ack_masked_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !int_en_o |-> !ack);
endmodule

// File: tb/daisy_irq_top_tb_top.sv
module daisy_irq_top_tb_top;
  localparam int N = 4;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   req;
  logic [N*W-1:0] vecs;
  logic           set_en, rti;
  logic           line_n, ack, en;
  logic [W-1:0]   vec;
  logic [N-1:0]   pend;

  int tests = 0;
  int fails = 0;
  logic [W-1:0] exp_q[$];
  logic ack_seen = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  daisy_irq_top #(.N_DEV(N), .VEC_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .dev_req_i(req), .dev_vec_i(vecs),
    .set_en_i(set_en), .rti_i(rti), .irq_line_n_o(line_n), .ack_o(ack),
    .vec_o(vec), .int_en_o(en), .pend_o(pend)
  );

  for (genvar g = 0; g < N; g++) begin : g_vec
    assign vecs[g*W +: W] = W'(8'hA0 + g);
  end

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect_vec(int dev);
    exp_q.push_back(W'(8'hA0 + dev));
  endtask

  // monitor: vector captured one edge after an observed acknowledge (R5)
  always @(negedge clk) begin
    if (ack_seen) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5 actual=%0h expected=<none>", vec);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        if (vec !== e) begin
          fails++;
          $display("FAIL R5/R4 actual=%0h expected=%0h", vec, e);
        end
      end
    end
    ack_seen = ack;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = '0; set_en = 1'b0; rti = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    // R9 reset state
    check("R9 line", line_n, 1);
    check("R9 ack", ack, 0);
    check("R9 en", en, 0);
    check("R9 vec", vec, 0);
    check("R9 pend", pend, 0);

    // masked requests stay pending (R2, R6, R1)
    req[2] = 1'b1; step();
    check("R2 latch", pend, 4'b0100);
    check("R1 line low", line_n, 0);
    check("R6 no ack masked", ack, 0);
    req[1] = 1'b1; repeat (3) step();
    check("R6 kept pending", pend, 4'b0110);
    check("R6 still no ack", ack, 0);

    // enable: head-most pending (dev1) first (R7, R4, R3)
    set_en = 1'b1; expect_vec(1); step(); set_en = 1'b0;
    check("R3 ack on enable", ack, 1);
    step();
    check("R4 dev1 taken, dev2 kept", pend, 4'b0100);
    check("R6 en cleared", en, 0);
    check("R3 single pulse", ack, 0);

    // return: next pending taken (R7)
    rti = 1'b1; expect_vec(2); step(); rti = 1'b0;
    check("R7 ack after rti", ack, 1);
    step();
    check("R7 pend clear", pend, 0);
    check("R1 line high", line_n, 1);

    // held level does not retrigger (R2)
    rti = 1'b1; step(); rti = 1'b0; repeat (3) step();
    check("R2 no retrigger", pend, 0);
    check("R3 idle no ack", ack, 0);
    check("R7 en set idle", en, 1);
    req = '0; step();

    // simultaneous head and tail (R4)
    req[0] = 1'b1; req[3] = 1'b1; expect_vec(0); step();
    check("R3 ack same cycle", ack, 1);
    step();
    check("R4 tail kept", pend, 4'b1000);
    rti = 1'b1; expect_vec(3); step(); rti = 1'b0; step();
    check("R4 tail later", pend, 0);
    req = '0; step();

    // lone tail: pass-through in first cycle (R10)
    rti = 1'b1; step(); rti = 1'b0;
    req[3] = 1'b1; expect_vec(3); step();
    check("R10 line low", line_n, 0);
    check("R10 ack same cycle", ack, 1);
    step();

    // nesting during service (R7)
    req[1] = 1'b1; step();
    check("R6 pending in service", pend, 4'b0010);
    set_en = 1'b1; expect_vec(1); step(); set_en = 1'b0;
    check("R7 nested ack", ack, 1);
    step();
    req = '0; step();

    // request arriving in acknowledge cycle (R8)
    req[2] = 1'b1; step();
    set_en = 1'b1; expect_vec(2); step(); set_en = 1'b0;
    req[0] = 1'b1;
    check("R8 ack in flight", ack, 1);
    step();
    check("R8 late head kept", pend, 4'b0001);
    check("R8 no ack", ack, 0);
    rti = 1'b1; expect_vec(0); step(); rti = 1'b0; step();
    check("R8 late head taken", pend, 0);

    repeat (3) step();
    check("R5 all vectors seen", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule